// File: doc/BRIEF.md
# Serial Command Receiver with Frame Watchdog

This block is the serial slave front end of a four-channel output controller. A host clocks 16-bit command words into it, most significant bit first. Bits are taken on rising serial clock edges while the active-low select is held low. A word counts only when select returns high after a whole number of 16-bit words. Each word is then split into four parts: a watchdog bit, a two-bit channel number, a three-bit register selector and a nine-bit payload. The payload goes into one configuration register. Selector zero addresses one global register. Selectors one to seven each address a bank of four per-channel registers.

Several words can be sent in one select window, so that devices can be chained. The bit that leaves the top of the shift register is driven on the serial output, and only the last word received in the window is acted upon. The watchdog bit has to change from one accepted word to the next. A counter in the system clock domain counts cycles since the last change and raises a timeout flag once it reaches a limit taken from an input port. The serial clock, select and data lines are asynchronous to the system clock and pass through synchronizers before any edge is detected.

Top module: `spi_cmd_rx`

## Requirements
- R1: After a synchronous active-low reset, all configuration registers, the serial output and the watchdog counter are zero. The timeout flag is low whenever the limit is non-zero.
- R2: The word is assembled from the serial data line, one bit per rising serial clock edge while select is low, with the first bit becoming bit 15. Fields: bit 15 watchdog, bits 14:13 channel, bits 12:10 selector, bit 9 spare, bits 8:0 payload.
- R3: An accepted word with selector 1 to 7 writes its payload only into the register of that selector for the channel given by bits 14:13. All other registers keep their value.
- R4: An accepted word with selector 0 writes its payload into the global register, whatever bits 14:13 hold.
- R5: Bit 9 has no effect on any register.
- R6: A select window of 16·k bits (k ≥ 1) is accepted, and only the last 16 bits received act.
- R7: A select window whose bit count is not a multiple of 16 changes no register and does not clear the watchdog.
- R8: A select window with no serial clock edges changes nothing.
- R9: On every accepted serial clock edge, the serial output takes the value of bit 14 of the shift register as it was before the shift. Words therefore leave the block in the order they entered it.
- R10: The watchdog counter is cleared only by an accepted word whose bit 15 differs from that of the previous accepted word. The value before the first such word is 0.
- R11: The counter advances once per system clock up to the limit and stays there. The timeout flag is high exactly while the counter is at or above the limit.
- R12: Serial clock edges while select is high neither shift nor count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| cs_n_i | input | 1 | Active-low select, asynchronous |
| si_i | input | 1 | Serial data in |
| wd_limit_i | input | WD_W | Watchdog limit in system clock cycles |
| so_o | output | 1 | Serial data out (MSB of shift register) |
| glb_cfg_o | output | 9 | Global configuration register |
| ch_cfg_o | output | 252 | Per-channel registers, entry (sel-1)*4+ch at bits [entry*9 +: 9] |
| wd_timeout_o | output | 1 | Watchdog timeout flag |

## Verification
The bench builds the block with two synchronizer stages and a 12-bit watchdog counter, and it drives a limit of 300 cycles. At that limit the timeout is reached after one idle stretch of a few hundred cycles. Reaching it again and clearing it then takes only a handful of words. Each serial level is held for three system clocks. This keeps the synchronizer latency visible cycle by cycle, while still allowing chained 32-bit windows, 15- and 17-bit partial windows and stray serial clocks within a short run.

// File: rtl/cmdrx_pkg.sv
// Shared constants for the serial command receiver: frame layout and
// register bank geometry. Field positions are fixed by the frame format.
package cmdrx_pkg;
    localparam int FRAME_W  = 16;
    localparam int DATA_W   = 9;
    localparam int CH_W     = 2;
    localparam int SEL_W    = 3;
    localparam int POS_WD   = 15;
    localparam int POS_CH   = 13;
    localparam int POS_SEL  = 10;
    localparam int NUM_CH   = 1 << CH_W;
    localparam int NUM_SEL  = 1 << SEL_W;
    localparam int NUM_BANK = (NUM_SEL - 1) * NUM_CH;
    localparam int BANK_BITS = NUM_BANK * DATA_W;
    localparam int CNT_W    = $clog2(FRAME_W);
endpackage

// File: rtl/cmdrx_sync_edge.sv
// Synchronizes serial clock, select and data into the system clock domain
// and detects rising edges of serial clock and select.
// Assumes each serial level is held for at least two system clocks.
module cmdrx_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic si_i,
    output logic sclk_rise_o,
    output logic cs_rise_o,
    output logic cs_hi_o,
    output logic si_o
);
    logic [STAGES-1:0] sclk_p, cs_p, si_p;
    logic              sclk_d, cs_d;

    // Synchronizer chains; select idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= '0;
            cs_p   <= '1;
            si_p   <= '0;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_p <= {sclk_p[STAGES-2:0], sclk_i};
            cs_p   <= {cs_p[STAGES-2:0], cs_n_i};
            si_p   <= {si_p[STAGES-2:0], si_i};
            sclk_d <= sclk_p[STAGES-1];
            cs_d   <= cs_p[STAGES-1];
        end
    end

    // Edge detection on the synchronized levels.
    always_comb begin
        sclk_rise_o = sclk_p[STAGES-1] & ~sclk_d;
        cs_rise_o   = cs_p[STAGES-1] & ~cs_d;
        cs_hi_o     = cs_p[STAGES-1];
        si_o        = si_p[STAGES-1];
    end
endmodule

// File: rtl/cmdrx_shifter.sv
// Shift register and bit counter. Accepts a frame on select rise when at
// least one bit arrived and the count is a multiple of FRAME_W.
// Assumes synchronized, single-cycle edge pulses from cmdrx_sync_edge.
module cmdrx_shifter
    import cmdrx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise_i,
    input  logic               cs_rise_i,
    input  logic               cs_hi_i,
    input  logic               si_i,
    output logic               frame_vld_o,
    output logic               wd_o,
    output logic [CH_W-1:0]    ch_o,
    output logic [SEL_W-1:0]   sel_o,
    output logic [DATA_W-1:0]  data_o,
    output logic               so_o
);
    logic [FRAME_W-1:0] shift_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               seen_q;

    // Shift on serial clock while selected; clear count on select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
            seen_q  <= 1'b0;
        end else if (cs_rise_i) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (sclk_rise_i && !cs_hi_i) begin
            shift_q <= {shift_q[FRAME_W-2:0], si_i};
            cnt_q   <= cnt_q + 1'b1;
            seen_q  <= 1'b1;
        end
    end

    // Frame acceptance and field extraction.
    always_comb begin
        frame_vld_o = cs_rise_i && seen_q && (cnt_q == '0);
        wd_o        = shift_q[POS_WD];
        ch_o        = shift_q[POS_CH +: CH_W];
        sel_o       = shift_q[POS_SEL +: SEL_W];
        data_o      = shift_q[DATA_W-1:0];
        so_o        = shift_q[FRAME_W-1];
    end

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi_i |=> $stable(shift_q));

    assert_so_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise_i && !cs_hi_i) |=> (so_o == $past(shift_q[FRAME_W-2])));
endmodule

// File: rtl/cmdrx_regfile.sv
// Global register plus per-channel banks. A write goes to the global
// register for selector zero, else to the bank entry (sel, ch).
// Assumes wr_en_i is a single-cycle pulse.
module cmdrx_regfile
    import cmdrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [CH_W-1:0]      ch_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [DATA_W-1:0]    data_i,
    output logic [DATA_W-1:0]    glb_cfg_o,
    output logic [BANK_BITS-1:0] ch_cfg_o
);
    logic [NUM_BANK:0]                  we;
    logic [NUM_BANK-1:0][DATA_W-1:0]    bank_q;
    logic [DATA_W-1:0]                  glb_q;

    // Decode one write enable per register; bit 0 is the global register.
    always_comb begin
        we    = '0;
        we[0] = wr_en_i && (sel_i == '0);
        for (int s = 1; s < NUM_SEL; s++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                we[1 + (s - 1) * NUM_CH + c] = wr_en_i &&
                    (sel_i == SEL_W'(s)) && (ch_i == CH_W'(c));
            end
        end
    end

    // Register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_q  <= '0;
            bank_q <= '0;
        end else begin
            if (we[0]) glb_q <= data_i;
            for (int b = 0; b < NUM_BANK; b++) begin
                if (we[b + 1]) bank_q[b] <= data_i;
            end
        end
    end

    assign glb_cfg_o = glb_q;
    assign ch_cfg_o  = bank_q;

    assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));

    assert_no_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(glb_q) && $stable(bank_q)));
endmodule

// File: rtl/cmdrx_wdog.sv
// Frame watchdog: counts system clocks since the last accepted frame whose
// watchdog bit changed, saturating at the limit; flags timeout at the limit.
// Assumes frame_vld_i is a single-cycle pulse.
module cmdrx_wdog #(
    parameter int WD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_vld_i,
    input  logic            wd_bit_i,
    input  logic [WD_W-1:0] limit_i,
    output logic            timeout_o
);
    logic [WD_W-1:0] cnt_q;
    logic            last_q;
    logic            toggle;

    assign toggle = frame_vld_i && (wd_bit_i != last_q);

    // Clear on a toggle, otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else if (toggle) begin
            cnt_q  <= '0;
            last_q <= wd_bit_i;
        end else if (cnt_q < limit_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign timeout_o = (cnt_q >= limit_i);

    assert_toggle_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> (cnt_q == '0));

    assert_timeout_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !toggle) |=> (timeout_o || (limit_i != $past(limit_i))));
endmodule

// File: rtl/spi_cmd_rx.sv
// Top: serial command receiver with per-channel configuration registers
// and a toggle watchdog. Assumes serial inputs are asynchronous and slow
// compared with clk (each level held at least STAGES+1 system clocks).
module spi_cmd_rx
    import cmdrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WD_W        = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_i,
    input  logic                 cs_n_i,
    input  logic                 si_i,
    input  logic [WD_W-1:0]      wd_limit_i,
    output logic                 so_o,
    output logic [DATA_W-1:0]    glb_cfg_o,
    output logic [BANK_BITS-1:0] ch_cfg_o,
    output logic                 wd_timeout_o
);
    logic sclk_rise, cs_rise, cs_hi, si_s;
    logic frame_vld, frm_wd;
    logic [CH_W-1:0]   frm_ch;
    logic [SEL_W-1:0]  frm_sel;
    logic [DATA_W-1:0] frm_data;

    cmdrx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(sclk_i), .cs_n_i(cs_n_i), .si_i(si_i),
        .sclk_rise_o(sclk_rise), .cs_rise_o(cs_rise),
        .cs_hi_o(cs_hi), .si_o(si_s)
    );

    cmdrx_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise_i(sclk_rise), .cs_rise_i(cs_rise),
        .cs_hi_i(cs_hi), .si_i(si_s),
        .frame_vld_o(frame_vld), .wd_o(frm_wd), .ch_o(frm_ch),
        .sel_o(frm_sel), .data_o(frm_data), .so_o(so_o)
    );

    cmdrx_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(frame_vld),
        .ch_i(frm_ch), .sel_i(frm_sel), .data_i(frm_data),
        .glb_cfg_o(glb_cfg_o), .ch_cfg_o(ch_cfg_o)
    );

    cmdrx_wdog #(.WD_W(WD_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .frame_vld_i(frame_vld),
        .wd_bit_i(frm_wd), .limit_i(wd_limit_i), .timeout_o(wd_timeout_o)
    );
endmodule

// File: tb/tb_spi_cmd_rx.sv
`timescale 1ns/1ps
module tb_spi_cmd_rx;
    localparam int S    = 2;
    localparam int WDW  = 12;
    localparam int LIM  = 300;
    localparam int HALF = 3;

    logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, si = 0;
    logic [WDW-1:0] lim = WDW'(LIM);
    logic so, tmo;
    logic [8:0] glb;
    logic [251:0] cfg;

    spi_cmd_rx #(.SYNC_STAGES(S), .WD_W(WDW)) dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .si_i(si),
        .wd_limit_i(lim), .so_o(so), .glb_cfg_o(glb), .ch_cfg_o(cfg),
        .wd_timeout_o(tmo)
    );

    always #2.5 clk = ~clk;

    int nchk = 0, nfail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising clock.
    bit hs[8], hc[8], hi[8];
    bit [15:0] msh;
    int mcnt, mwd;
    bit mseen, mlast, mso;
    bit [8:0] mglb;
    bit [8:0] mb[8][4];

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (hs[i]) begin hs[i] = 0; hc[i] = 1; hi[i] = 0; end
            msh = 0; mcnt = 0; mseen = 0; mlast = 0; mwd = 0; mglb = 0;
            foreach (mb[a, b]) mb[a][b] = 0;
        end else begin
            bit latch, srise, crise;
            bit [15:0] lf;
            for (int i = 7; i > 0; i--) begin hs[i] = hs[i-1]; hc[i] = hc[i-1]; hi[i] = hi[i-1]; end
            hs[0] = sclk; hc[0] = cs_n; hi[0] = si;
            srise = hs[S] && !hs[S+1];
            crise = hc[S] && !hc[S+1];
            latch = 0; lf = 0;
            if (crise) begin
                if (mseen && (mcnt % 16 == 0)) begin latch = 1; lf = msh; end
                mcnt = 0; mseen = 0;
            end else if (srise && !hc[S]) begin
                msh = {msh[14:0], hi[S]}; mcnt++; mseen = 1;
            end
            if (latch) begin
                if (lf[12:10] == 0) mglb = lf[8:0];
                else mb[lf[12:10]][lf[14:13]] = lf[8:0];
            end
            if (latch && lf[15] != mlast) begin mwd = 0; mlast = lf[15]; end
            else if (mwd < LIM) mwd++;
        end
        mso = msh[15];
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [251:0] ecfg;
            for (int s = 1; s < 8; s++)
                for (int c = 0; c < 4; c++)
                    ecfg[((s-1)*4+c)*9 +: 9] = mb[s][c];
            chk(glb == mglb, "R4 glb", 256'(glb), 256'(mglb));
            chk(cfg == ecfg, "R3 bank", 256'(cfg), 256'(ecfg));
            chk(so == mso, "R9 so", 256'(so), 256'(mso));
            chk(tmo == (mwd >= LIM), "R11 timeout", 256'(tmo), 256'(mwd >= LIM));
        end
    end

    function automatic logic [15:0] mk(bit w, int ch, int sel, bit d9, int d);
        return {w, 2'(ch), 3'(sel), d9, 9'(d)};
    endfunction

    function automatic logic [8:0] cfg_at(int sel, int ch);
        return cfg[((sel-1)*4+ch)*9 +: 9];
    endfunction

    task automatic wt(int n); repeat (n) @(negedge clk); endtask

    task automatic spi(input logic [63:0] bits, input int n);
        cs_n = 0; wt(HALF);
        for (int i = 0; i < n; i++) begin
            si = bits[n-1-i]; wt(HALF);
            sclk = 1; wt(HALF);
            sclk = 0;
        end
        wt(HALF); cs_n = 1; wt(12);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++; nchk++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        wt(4); rst_n = 1; wt(1);
        // R1: reset state
        chk(glb == 0 && cfg == 0, "R1 regs", 256'(glb), 0);
        chk(so == 0 && tmo == 0, "R1 so/tmo", 256'({so, tmo}), 0);

        // R2/R3: channel write
        spi(64'(mk(1, 2, 3, 0, 9'h1A5)), 16);
        chk(cfg_at(3, 2) == 9'h1A5, "R2 R3 sel3 ch2", 256'(cfg_at(3, 2)), 256'(9'h1A5));
        chk(cfg_at(3, 1) == 0, "R3 neighbour", 256'(cfg_at(3, 1)), 0);

        // R4: global, channel bits ignored
        spi(64'(mk(0, 3, 0, 0, 9'h0F3)), 16);
        chk(glb == 9'h0F3, "R4 global", 256'(glb), 256'(9'h0F3));
        chk(cfg_at(1, 3) == 0, "R4 no bank", 256'(cfg_at(1, 3)), 0);

        // R5: spare bit set
        spi(64'(mk(1, 1, 5, 1, 9'h055)), 16);
        chk(cfg_at(5, 1) == 9'h055, "R5 spare", 256'(cfg_at(5, 1)), 256'(9'h055));

        // R6/R9: two chained words, only the last acts
        spi({32'h0, mk(0, 0, 1, 0, 9'h111), mk(0, 1, 2, 0, 9'h022)}, 32);
        chk(cfg_at(2, 1) == 9'h022, "R6 last word", 256'(cfg_at(2, 1)), 256'(9'h022));
        chk(cfg_at(1, 0) == 0, "R6 first word dropped", 256'(cfg_at(1, 0)), 0);

        // R7: partial windows
        spi(64'(mk(1, 3, 6, 0, 9'h1FF)) >> 1, 15);
        chk(cfg_at(6, 3) == 0, "R7 15 bits", 256'(cfg_at(6, 3)), 0);
        spi({47'h0, 1'b1, mk(1, 3, 6, 0, 9'h1FF)}, 17);
        chk(cfg_at(6, 3) == 0, "R7 17 bits", 256'(cfg_at(6, 3)), 0);

        // R8: empty window
        cs_n = 0; wt(6); cs_n = 1; wt(12);
        chk(glb == 9'h0F3, "R8 empty window", 256'(glb), 256'(9'h0F3));

        // R12: stray clocks while deselected, then a clean word
        si = 1;
        for (int i = 0; i < 5; i++) begin sclk = 1; wt(HALF); sclk = 0; wt(HALF); end
        spi(64'(mk(1, 0, 7, 0, 9'h0AA)), 16);
        chk(cfg_at(7, 0) == 9'h0AA, "R12 stray clocks", 256'(cfg_at(7, 0)), 256'(9'h0AA));

        // R11/R10: idle to timeout, same bit keeps it, toggle clears
        wt(LIM + 100);
        chk(tmo == 1, "R11 timeout reached", 256'(tmo), 1);
        spi(64'(mk(1, 2, 4, 0, 9'h033)), 16);
        chk(tmo == 1, "R10 same bit no clear", 256'(tmo), 1);
        spi(64'(mk(0, 2, 4, 0, 9'h044)), 16);
        chk(tmo == 0, "R10 toggle clears", 256'(tmo), 0);
        chk(cfg_at(4, 2) == 9'h044, "R3 overwrite", 256'(cfg_at(4, 2)), 256'(9'h044));

        wt(5);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule